// File: doc/BRIEF.md
# Byte-Bus Converter Reader

This block is a host-side sequencer for a successive-approximation converter that has a chip-enable, an active-low chip select, a combined read/convert line, an address line, a bus-width select line and a busy status line. When the host raises a request, the block starts a conversion of the chosen length. It waits for the converter's status line to rise and then fall again. It then reads the result and returns it as one 12-bit word with a single-cycle valid strobe.

The result can be read in two ways. In wide mode the bus-width line is held high and one read returns all 12 bits. In byte mode only the upper eight data lines are used, and the result comes in two reads. The first read, with the address line low, returns the eight most significant bits. The second read, with the address line high, carries the four least significant bits in the upper half of the byte and zeros below them. The block joins the two reads back into one word. A timeout stops a sequence whose status handshake never completes and reports it on an error pulse. The conversion pulse width, the read access time, the gap between reads and the timeout are all parameters counted in clock cycles.

Top module: `cvr_reader`

## Requirements
- R1: While reset is applied, and in the first cycles after it, ready_o is 1, cv_ce_o is 0, cv_cs_n_o is 1, cv_rc_n_o is 1, and res_valid_o and err_o are 0.
- R2: A request taken while ready_o is 1 drives the start condition in the next cycle: cv_ce_o=1, cv_cs_n_o=0, cv_rc_n_o=0. In that condition cv_a0_o equals len8_i (0 selects a 12-bit conversion, 1 an 8-bit one).
- R3: cv_rc_n_o stays low for exactly PULSE_CYC cycles per conversion, and then rises.
- R4: No read strobe (cv_ce_o=1, cv_cs_n_o=0, cv_rc_n_o=1) is driven while cv_sts_i is 1, and none is driven before cv_sts_i has been seen high and then low.
- R5: In byte mode (wide_i=0 at the request), cv_wide_o is 0 and exactly two read strobes are issued. The first has cv_a0_o=0 and the second has cv_a0_o=1. The byte read is cv_data_i[11:4], and res_o = {first byte, upper nibble of second byte}.
- R6: In wide mode (wide_i=1 at the request), cv_wide_o is 1 and exactly one read strobe is issued, with cv_a0_o=0. res_o is cv_data_i[11:0].
- R7: res_valid_o is a one-cycle pulse, one per completed sequence, and res_o holds the assembled result while it is high.
- R8: If the status line has not both risen and fallen within TMO_CYC cycles after the conversion pulse ends, err_o pulses for one cycle. No read is issued, res_valid_o stays 0, and the block returns to ready.
- R9: ready_o is 0 from the cycle after a request is accepted until the sequence ends with res_valid_o or err_o. A request made during that time is ignored.
- R10: Each read strobe lasts exactly ACC_CYC cycles, and the data is captured in its last cycle. The two byte reads are separated by GAP_CYC idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request, taken when ready_o is 1 |
| len8_i | input | 1 | 1 selects an 8-bit conversion, 0 a 12-bit one |
| wide_i | input | 1 | 1 selects a single 12-bit read, 0 selects two byte reads |
| ready_o | output | 1 | Block is idle and accepts a request |
| res_o | output | 12 | Assembled conversion result |
| res_valid_o | output | 1 | One-cycle strobe, res_o is valid |
| err_o | output | 1 | One-cycle strobe, status handshake timed out |
| cv_ce_o | output | 1 | Converter chip enable, active high |
| cv_cs_n_o | output | 1 | Converter chip select, active low |
| cv_rc_n_o | output | 1 | Converter read/convert line, low starts a conversion |
| cv_a0_o | output | 1 | Converter address line: length at start, byte select at read |
| cv_wide_o | output | 1 | Converter bus-width line, high for a 12-bit read |
| cv_sts_i | input | 1 | Converter busy status |
| cv_data_i | input | 12 | Converter data lines, byte reads use bits 11:4 |

## Verification
A wrong sequencer state shows at the converter pins within one cycle. A read strobe would appear while the status line is still high, a strobe could have the wrong length, or the start pulse could differ from PULSE_CYC. A slip in the capture path shows only at the next res_valid_o strobe, as a result that differs from the value the converter model holds, so every code value is swept in byte mode to expose swapped or shifted nibbles. A stuck handshake counter shows as an err_o pulse that is missing or late, compared with the TMO_CYC window.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = RES_W - BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAITH,
    ST_WAITL,
    ST_RD1,
    ST_GAP,
    ST_RD2,
    ST_DONE,
    ST_ERR
  } cvr_state_e;

  typedef struct packed {
    logic ce;
    logic cs_n;
    logic rc_n;
    logic a0;
  } cvr_pins_t;

  function automatic int cvr_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/cvr_seq.sv
module cvr_seq
  import cvr_pkg::*;
#(
  parameter int PULSE_CYC = 3,
  parameter int ACC_CYC   = 2,
  parameter int GAP_CYC   = 1,
  parameter int TMO_CYC   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       len8_i,
  input  logic       wide_i,
  input  logic       sts_i,
  output cvr_state_e state_o,
  output logic       len8_o,
  output logic       wide_o,
  output logic       cap_hi_o,
  output logic       cap_lo_o
);

  localparam int MAXC = cvr_max4(PULSE_CYC, ACC_CYC, GAP_CYC, TMO_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] ACC_LAST   = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST   = CW'(TMO_CYC - 1);

  cvr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic len8_q, wide_q;
  logic cfg_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cfg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          cfg_en  = 1'b1;
          cnt_d   = '0;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (cnt_q == PULSE_LAST) begin
          cnt_d   = '0;
          state_d = ST_WAITH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAITH: begin
        if (cnt_q == TMO_LAST)  state_d = ST_ERR;
        else if (sts_i)         state_d = ST_WAITL;
        cnt_d = cnt_q + 1'b1;
      end
      ST_WAITL: begin
        if (!sts_i) begin
          cnt_d   = '0;
          state_d = ST_RD1;
        end else if (cnt_q == TMO_LAST) begin
          state_d = ST_ERR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RD1: begin
        if (cnt_q == ACC_LAST) begin
          cnt_d   = '0;
          state_d = wide_q ? ST_DONE : ST_GAP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == GAP_LAST) begin
          cnt_d   = '0;
          state_d = ST_RD2;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RD2: begin
        if (cnt_q == ACC_LAST) begin
          cnt_d   = '0;
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len8_q <= 1'b0;
      wide_q <= 1'b0;
    end else if (cfg_en) begin
      len8_q <= len8_i;
      wide_q <= wide_i;
    end
  end

  assign state_o  = state_q;
  assign len8_o   = len8_q;
  assign wide_o   = wide_q;
  assign cap_hi_o = (state_q == ST_RD1) && (cnt_q == ACC_LAST);
  assign cap_lo_o = (state_q == ST_RD2) && (cnt_q == ACC_LAST);

endmodule

// File: rtl/cvr_pindec.sv
module cvr_pindec
  import cvr_pkg::*;
(
  input  cvr_state_e state_i,
  input  logic       len8_i,
  output cvr_pins_t  pins_o,
  output logic       ready_o,
  output logic       valid_o,
  output logic       err_o
);

  always_comb begin
    pins_o  = '{ce: 1'b0, cs_n: 1'b1, rc_n: 1'b1, a0: 1'b0};
    ready_o = 1'b0;
    valid_o = 1'b0;
    err_o   = 1'b0;
    unique case (state_i)
      ST_IDLE: ready_o = 1'b1;
      ST_CONV: pins_o  = '{ce: 1'b1, cs_n: 1'b0, rc_n: 1'b0, a0: len8_i};
      ST_RD1:  pins_o  = '{ce: 1'b1, cs_n: 1'b0, rc_n: 1'b1, a0: 1'b0};
      ST_RD2:  pins_o  = '{ce: 1'b1, cs_n: 1'b0, rc_n: 1'b1, a0: 1'b1};
      ST_DONE: valid_o = 1'b1;
      ST_ERR:  err_o   = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/cvr_assemble.sv
module cvr_assemble
  import cvr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_hi_i,
  input  logic             cap_lo_i,
  input  logic             wide_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] res_o
);

  logic [RES_W-1:0] res_q, res_d;
  logic             res_en;

  always_comb begin
    res_en = cap_hi_i | cap_lo_i;
    res_d  = res_q;
    if (cap_hi_i) begin
      if (wide_i) res_d = data_i;
      else        res_d[RES_W-1:NIB_W] = data_i[RES_W-1:NIB_W];
    end else if (cap_lo_i) begin
      res_d[NIB_W-1:0] = data_i[RES_W-1:RES_W-NIB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign res_o = res_q;

endmodule

// File: rtl/cvr_reader.sv
module cvr_reader
  import cvr_pkg::*;
#(
  parameter int PULSE_CYC = 3,
  parameter int ACC_CYC   = 2,
  parameter int GAP_CYC   = 1,
  parameter int TMO_CYC   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        len8_i,
  input  logic        wide_i,
  output logic        ready_o,
  output logic [11:0] res_o,
  output logic        res_valid_o,
  output logic        err_o,
  output logic        cv_ce_o,
  output logic        cv_cs_n_o,
  output logic        cv_rc_n_o,
  output logic        cv_a0_o,
  output logic        cv_wide_o,
  input  logic        cv_sts_i,
  input  logic [11:0] cv_data_i
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  cvr_state_e state;
  logic       len8_q, wide_q, cap_hi, cap_lo;
  cvr_pins_t  pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cvr_seq #(
    .PULSE_CYC(PULSE_CYC),
    .ACC_CYC  (ACC_CYC),
    .GAP_CYC  (GAP_CYC),
    .TMO_CYC  (TMO_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (req_i),
    .len8_i  (len8_i),
    .wide_i  (wide_i),
    .sts_i   (cv_sts_i),
    .state_o (state),
    .len8_o  (len8_q),
    .wide_o  (wide_q),
    .cap_hi_o(cap_hi),
    .cap_lo_o(cap_lo)
  );

  cvr_pindec u_dec (
    .state_i(state),
    .len8_i (len8_q),
    .pins_o (pins),
    .ready_o(ready_o),
    .valid_o(res_valid_o),
    .err_o  (err_o)
  );

  cvr_assemble u_asm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_hi_i(cap_hi),
    .cap_lo_i(cap_lo),
    .wide_i  (wide_q),
    .data_i  (cv_data_i),
    .res_o   (res_o)
  );

  assign cv_ce_o   = pins.ce;
  assign cv_cs_n_o = pins.cs_n;
  assign cv_rc_n_o = pins.rc_n;
  assign cv_a0_o   = pins.a0;
  assign cv_wide_o = wide_q;

endmodule

// File: rtl/cvr_reader_chk.sv
module cvr_reader_chk #(
  parameter int PULSE_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic ready_o,
  input logic res_valid_o,
  input logic err_o,
  input logic cv_ce_o,
  input logic cv_cs_n_o,
  input logic cv_rc_n_o,
  input logic cv_sts_i
);

  localparam int LW = $clog2(PULSE_CYC + 2) + 1;

  logic [LW-1:0] low_run_q;
  logic          rd_strobe;

  assign rd_strobe = cv_ce_o && !cv_cs_n_o && cv_rc_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_run_q <= '0;
    else if (!cv_rc_n_o && low_run_q != '1) low_run_q <= low_run_q + 1'b1;
    else if (cv_rc_n_o)                 low_run_q <= '0;
  end

  // R2
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cv_rc_n_o && !cv_cs_n_o) |-> cv_ce_o);

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && req_i) |=> (cv_ce_o && !cv_cs_n_o && !cv_rc_n_o));

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_rc_n_o) |-> (low_run_q == LW'(PULSE_CYC)));

  // R4
  read_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strobe) |-> !$past(cv_sts_i));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!res_valid_o && !cv_ce_o));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && req_i) |=> !ready_o);

  // R9
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!cv_ce_o && !res_valid_o && !err_o));

endmodule

bind cvr_reader cvr_reader_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .ready_o    (ready_o),
  .res_valid_o(res_valid_o),
  .err_o      (err_o),
  .cv_ce_o    (cv_ce_o),
  .cv_cs_n_o  (cv_cs_n_o),
  .cv_rc_n_o  (cv_rc_n_o),
  .cv_sts_i   (cv_sts_i)
);

// File: tb/sim_cvr_reader.sv
`timescale 1ns/1ps
module sim_cvr_reader;

  localparam int PULSE_CYC = 3;
  localparam int ACC_CYC   = 2;
  localparam int GAP_CYC   = 1;
  localparam int TMO_CYC   = 64;
  localparam int CONV_CYC  = 5;
  localparam int MD_OK = 0, MD_DEAD = 1, MD_STUCK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, len8 = 1'b0, wide = 1'b0;
  logic ready, res_valid, err, ce, cs_n, rc_n, a0, wpin;
  logic [11:0] res;
  logic sts = 1'b0;
  logic [11:0] data;

  always #4 clk = ~clk;

  cvr_reader #(
    .PULSE_CYC(PULSE_CYC), .ACC_CYC(ACC_CYC), .GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .len8_i(len8), .wide_i(wide),
    .ready_o(ready), .res_o(res), .res_valid_o(res_valid), .err_o(err),
    .cv_ce_o(ce), .cv_cs_n_o(cs_n), .cv_rc_n_o(rc_n), .cv_a0_o(a0), .cv_wide_o(wpin),
    .cv_sts_i(sts), .cv_data_i(data)
  );

  // converter model
  int          mdl_mode = MD_OK;
  logic [11:0] vcur = 12'h000;
  logic        busy = 1'b0;
  logic        len8m = 1'b0;
  int          ccnt = 0;
  logic [11:0] eff;

  assign eff = len8m ? {vcur[11:4], 4'b1000} : vcur;

  always_comb begin
    data = 12'hA5A;
    if (ce && !cs_n && rc_n) begin
      if (wpin)    data = eff;
      else if (a0) data = {eff[3:0], 4'h0, 4'h5};
      else         data = {eff[11:4], 4'h5};
    end
  end

  always @(negedge clk) begin
    if (busy) begin
      if (mdl_mode != MD_STUCK) begin
        if (ccnt == 0) begin sts <= 1'b0; busy <= 1'b0; end
        else ccnt <= ccnt - 1;
      end
    end else if (ce && !cs_n && !rc_n && mdl_mode != MD_DEAD) begin
      busy <= 1'b1; sts <= 1'b1; ccnt <= CONV_CYC - 1; len8m <= a0;
    end
  end

  // monitor, cumulative counts
  int n_valid = 0, n_err = 0, n_runs = 0, n_bad_rd = 0, n_illegal = 0;
  int n_bad_rc = 0, n_rdy_bad = 0, rd_len = 0, rc_len = 0;
  int n_a0_bad = 0;
  logic [11:0] last_res = 12'h000;
  logic first_a0_seen;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (ce && !cs_n && rc_n) begin
        if (rd_len == 0 && a0 != (n_runs_local_is_second() ? 1'b1 : 1'b0)) n_a0_bad++;
        rd_len++;
        if (sts) n_illegal++;
      end else if (rd_len != 0) begin
        n_runs++;
        if (rd_len != ACC_CYC) n_bad_rd++;
        rd_len = 0;
      end
      if (ce && !cs_n && !rc_n) rc_len++;
      else if (rc_len != 0) begin
        if (rc_len != PULSE_CYC) n_bad_rc++;
        rc_len = 0;
      end
      if (res_valid) begin n_valid++; last_res = res; end
      if (err) n_err++;
      if (ready && (ce || res_valid || err)) n_rdy_bad++;
    end
  end

  int runs_at_start = 0;
  function automatic logic n_runs_local_is_second();
    return (!wpin) && (n_runs != runs_at_start);
  endfunction

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [11:0] v, input logic l8, input logic wd,
                     input int mode, input logic poke);
    int sv, se, sr, sb, si, sc, sa, sy, cyc;
    logic [11:0] exp_v;
    sv = n_valid; se = n_err; sr = n_runs; sb = n_bad_rd; si = n_illegal;
    sc = n_bad_rc; sa = n_a0_bad; sy = n_rdy_bad;
    runs_at_start = n_runs;
    vcur = v; mdl_mode = mode;
    exp_v = l8 ? {v[11:4], 4'b1000} : v;
    @(posedge clk); #2;
    chk(ready == 1'b1, "R9 ready before request", ready, 1);
    req = 1'b1; len8 = l8; wide = wd;
    @(posedge clk); #2;
    req = 1'b0;
    // R2 start condition
    chk(ce && !cs_n && !rc_n && a0 == l8, "R2 start pins", {ce, cs_n, rc_n, a0}, {3'b100, l8});
    chk(ready == 1'b0, "R9 busy after accept", ready, 0);
    if (poke) begin
      @(posedge clk); #2; req = 1'b1; len8 = ~l8;
      @(posedge clk); #2; req = 1'b0;
    end
    cyc = 0;
    while (n_valid == sv && n_err == se && cyc < 300) begin
      @(posedge clk); #2; cyc++;
    end
    @(posedge clk); #2;
    if (mode == MD_OK) begin
      chk(n_valid - sv == 1 && n_err == se, "R7 one valid", n_valid - sv, 1);
      if (wd) chk(last_res == exp_v, "R6 wide result", last_res, exp_v);
      else    chk(last_res == exp_v, "R5 byte result", last_res, exp_v);
      chk(n_runs - sr == (wd ? 1 : 2), wd ? "R6 read count" : "R5 read count", n_runs - sr, wd ? 1 : 2);
      chk(n_a0_bad == sa, "R5 read address order", n_a0_bad - sa, 0);
      chk(n_bad_rd == sb, "R10 read strobe length", n_bad_rd - sb, 0);
      chk(n_bad_rc == sc, "R3 convert pulse length", n_bad_rc - sc, 0);
      chk(n_illegal == si, "R4 read while busy", n_illegal - si, 0);
    end else begin
      chk(n_err - se == 1 && n_valid == sv, "R8 timeout error", n_err - se, 1);
      chk(cyc >= TMO_CYC && cyc <= TMO_CYC + PULSE_CYC + 4, "R8 timeout latency", cyc, TMO_CYC);
      chk(n_runs == sr, "R8 no read on timeout", n_runs - sr, 0);
    end
    chk(n_rdy_bad == sy, "R9 ready during sequence", n_rdy_bad - sy, 0);
    chk(ready == 1'b1, "R9 ready after end", ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(ready && !ce && cs_n && rc_n && !res_valid && !err, "R1 reset outputs",
        {ready, ce, cs_n, rc_n, res_valid, err}, 6'b101100);
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;
    chk(ready && !ce && cs_n && rc_n && !res_valid && !err, "R1 after release",
        {ready, ce, cs_n, rc_n, res_valid, err}, 6'b101100);
    // R9 busy request ignored
    txn(12'h5C3, 1'b0, 1'b0, MD_OK, 1'b1);
    chk(n_valid == 1, "R9 extra request ignored", n_valid, 1);
    // R5 full byte-mode sweep
    for (int v = 0; v < 4096; v++) txn(v[11:0], 1'b0, 1'b0, MD_OK, 1'b0);
    // R6 wide-mode sweep
    for (int v = 0; v < 4096; v += 3) txn(v[11:0], 1'b0, 1'b1, MD_OK, 1'b0);
    txn(12'hFFF, 1'b0, 1'b1, MD_OK, 1'b0);
    // R2 8-bit conversions in both read modes
    for (int v = 0; v < 4096; v += 17) begin
      txn(v[11:0], 1'b1, 1'b0, MD_OK, 1'b0);
      txn(v[11:0], 1'b1, 1'b1, MD_OK, 1'b0);
    end
    // R8 status never rises, then never falls
    txn(12'h123, 1'b0, 1'b0, MD_DEAD, 1'b0);
    txn(12'h456, 1'b0, 1'b1, MD_STUCK, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule